// File: doc/BRIEF.md
# Private interrupt pending tracker

This block holds the pending state of the 32 interrupts private to one core. Interrupts 0 to 15 are software-generated. Each one becomes pending only through an injection request, which names the interrupt, the group the requester asks for and whether the requester is non-secure. Interrupts 16 to 31 are peripheral lines. Each line is configured as level-sensitive or as edge-triggered.

The block keeps one pending latch per interrupt. A register bank can set or clear each latch with one-cycle strobes. A latch is also set by a rising edge on an edge-triggered peripheral line, or by an injection that is accepted. The pending vector the block reports merges the latches with the live level of each level-sensitive line. As a result, a level interrupt stays pending for as long as its line is high, whatever the latch holds.

Each injection is checked against the group configured for the target interrupt. When security is enabled and the requester is non-secure, the injection is also checked against a 2-bit access field for that interrupt. The block answers every injection with a one-cycle accept pulse or a one-cycle reject pulse. Priority arbitration and delivery of the interrupt to the core are done elsewhere.

Top module: `pend_tracker`

## Requirements
- R1: After reset, `pend_o`, `inj_ack` and `inj_nak` are all zero.
- R2: Line levels are registered once per clock. Bit 16+j of `pend_o` is the latch of that bit OR (the registered level of `line_lvl[j]` AND NOT `edge_cfg[j]`). Bits 0..15 of `pend_o` equal their latches. A change on `line_lvl` therefore shows on `pend_o` after one clock edge.
- R3: A 0-to-1 change of `line_lvl[j]` between two consecutive samples sets latch 16+j only when `edge_cfg[j]` is 1 (1 means edge-triggered). A line that is level-sensitive never sets its latch.
- R4: A sample equal to the previous sample changes no state. An edge-triggered line that is held high does not set its latch again after the latch has been cleared.
- R5: `clr_strobe[i]` clears only latch i. A level-sensitive line that is still high keeps its bit of `pend_o` at 1.
- R6: When a set source and `clr_strobe[i]` act on the same bit in the same cycle, the set wins. Set sources are `set_strobe[i]`, a line edge and an accepted injection.
- R7: The configured group of software interrupt k is Non-secure Group 1 if `grp_cfg[k]`=1, Secure Group 1 if `grp_cfg[k]`=0 and `grpmod_cfg[k]`=1, and Group 0 otherwise. The request code `inj_grp` is 0 for Group 0, 1 for Secure Group 1 and 2 for Non-secure Group 1; code 3 is always rejected. An injection is rejected when the requested group differs from the configured group. The one exception is a Secure Group 1 request aimed at a Group 0 interrupt, which is handled as a Group 0 request.
- R8: The access field of software interrupt k is `ns_policy[2k+1:2k]`. The field is checked only when `sec_en`=1 and `inj_ns`=1. In that case a Group 0 target needs a field of at least 1, and a Secure Group 1 target needs a field of at least 2. A Non-secure Group 1 target needs no particular field value.
- R9: The block answers each injection one cycle after the request with exactly one pulse: `inj_ack` if accepted or `inj_nak` if rejected. An accepted injection sets latch `inj_id` at the same edge. A rejected injection changes no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_en | input | 1 | Security enabled; turns on the access-field checks |
| line_lvl | input | 16 | Raw levels of the peripheral lines for interrupts 16..31 |
| edge_cfg | input | 16 | 1 = edge-triggered, 0 = level-sensitive, per peripheral line |
| set_strobe | input | 32 | One-cycle set-pending strobes, one per interrupt |
| clr_strobe | input | 32 | One-cycle clear-pending strobes, one per interrupt |
| grp_cfg | input | 16 | Group bit per software interrupt (1 = Non-secure Group 1) |
| grpmod_cfg | input | 16 | Group modifier per software interrupt (1 with group bit 0 = Secure Group 1) |
| ns_policy | input | 32 | Non-secure access fields, 2 bits per software interrupt |
| inj_valid | input | 1 | Injection request valid for one cycle |
| inj_id | input | 4 | Target software interrupt of the injection |
| inj_grp | input | 2 | Requested group code (0, 1, 2; 3 is invalid) |
| inj_ns | input | 1 | Injection comes from the non-secure side |
| pend_o | output | 32 | Effective pending vector |
| inj_ack | output | 1 | Injection accepted, one cycle after the request |
| inj_nak | output | 1 | Injection rejected, one cycle after the request |

## Verification
If a latch bit is wrong, the error shows on its bit of `pend_o` right after the clock edge that set it. The one exception is a level-sensitive line that is high, which hides its latch until the line drops. A missed edge or a spurious relatch after a clear therefore shows one cycle after the line sample. An acceptance decision that is wrong shows twice in the cycle after the request: on the ack/nak pair, and in whether bit `inj_id` of `pend_o` rose. The sweep covers every combination of target, group code, configured group, requester security, security enable and field value. It places a different value in the other access fields, so a field read from the wrong position also shows on these outputs.

// File: rtl/pend_pkg.sv
package pend_pkg;

    localparam int NUM_SGI   = 16;
    localparam int NUM_PER   = 16;
    localparam int NUM_IRQ   = NUM_SGI + NUM_PER;
    localparam int SGI_ID_W  = $clog2(NUM_SGI);
    localparam int FIELD_W   = 2;
    localparam int POLICY_W  = NUM_SGI * FIELD_W;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2,
        GRP_BAD  = 2'd3
    } grp_e;

    typedef struct packed {
        logic                valid;
        logic [SGI_ID_W-1:0] id;
        grp_e                grp;
        logic                ns;
    } inj_req_t;

    typedef struct packed {
        logic ack;
        logic nak;
    } inj_rsp_t;

    function automatic grp_e cfg_group(input logic grp_bit, input logic mod_bit);
        if (grp_bit)
            return GRP_G1NS;
        else if (mod_bit)
            return GRP_G1S;
        else
            return GRP_G0;
    endfunction

    function automatic logic group_match(input grp_e req, input grp_e cfg);
        if (req == GRP_BAD)
            return 1'b0;
        else if (req == cfg)
            return 1'b1;
        else if (req == GRP_G1S && cfg == GRP_G0)
            return 1'b1;
        else
            return 1'b0;
    endfunction

    function automatic logic policy_ok(input grp_e cfg, input logic [FIELD_W-1:0] field);
        case (cfg)
            GRP_G0:  return field >= 2'd1;
            GRP_G1S: return field >= 2'd2;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pend_line_sampler.sv
module pend_line_sampler
    import pend_pkg::*;
#(
    parameter int LINES = NUM_PER
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    input  logic [LINES-1:0] edge_cfg,
    output logic [LINES-1:0] lvl_q,
    output logic [LINES-1:0] edge_set
);

    genvar j;
    generate
        for (j = 0; j < LINES; j++) begin : g_line
            logic rising;

            always_comb begin
                rising      = line_in[j] && !lvl_q[j];
                edge_set[j] = rising && edge_cfg[j];
            end

            always_ff @(posedge clk) begin
                if (rst)
                    lvl_q[j] <= 1'b0;
                else if (line_in[j] != lvl_q[j])
                    lvl_q[j] <= line_in[j];
            end

            // R3: an edge request is followed by a recorded high level
            assert_edge_records_high_R3: assert property (@(posedge clk) disable iff (rst)
                edge_set[j] |=> lvl_q[j]);

            // R4: a recorded level only moves when the sample differed
            assert_level_stable_R4: assert property (@(posedge clk) disable iff (rst)
                (line_in[j] == lvl_q[j]) |=> $stable(lvl_q[j]));
        end
    endgenerate

endmodule

// File: rtl/pend_inject_gate.sv
module pend_inject_gate
    import pend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sec_en,
    input  inj_req_t            req,
    input  logic [NUM_SGI-1:0]  grp_cfg,
    input  logic [NUM_SGI-1:0]  grpmod_cfg,
    input  logic [POLICY_W-1:0] ns_policy,
    output logic [NUM_SGI-1:0]  sgi_set,
    output inj_rsp_t            rsp
);

    grp_e               tgt_grp;
    logic [FIELD_W-1:0] tgt_field;
    logic               match_ok;
    logic               access_ok;
    logic               accept;

    always_comb begin
        tgt_grp   = cfg_group(grp_cfg[req.id], grpmod_cfg[req.id]);
        tgt_field = ns_policy[req.id*FIELD_W +: FIELD_W];
        match_ok  = group_match(req.grp, tgt_grp);
        if (sec_en && req.ns)
            access_ok = policy_ok(tgt_grp, tgt_field);
        else
            access_ok = 1'b1;
        accept = req.valid && match_ok && access_ok;
    end

    genvar k;
    generate
        for (k = 0; k < NUM_SGI; k++) begin : g_sgi
            assign sgi_set[k] = accept && (req.id == SGI_ID_W'(k));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.ack <= accept;
            rsp.nak <= req.valid && !accept;
        end
    end

    // R9: at most one answer per cycle
    assert_single_answer_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp.ack, rsp.nak}));

    // R9: every answer belongs to a request of the previous cycle
    assert_answer_has_request_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp.ack || rsp.nak) |-> $past(req.valid));

    // R9: every request gets an answer
    assert_request_answered_R9: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> (rsp.ack || rsp.nak));

    // R7: an invalid group code is never accepted
    assert_bad_code_rejected_R7: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.grp == GRP_BAD) |=> rsp.nak);

    // R8: a secure request or disabled security never fails on the field
    assert_secure_skips_field_R8: assert property (@(posedge clk) disable iff (rst)
        (req.valid && (!sec_en || !req.ns) && match_ok) |=> rsp.ack);

endmodule

// File: rtl/pend_latch_bank.sv
module pend_latch_bank
    import pend_pkg::*;
#(
    parameter int BITS = NUM_IRQ
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [BITS-1:0] set_vec,
    input  logic [BITS-1:0] clr_vec,
    output logic [BITS-1:0] latch_q
);

    genvar i;
    generate
        for (i = 0; i < BITS; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    latch_q[i] <= 1'b0;
                else if (set_vec[i])
                    latch_q[i] <= 1'b1;
                else if (clr_vec[i])
                    latch_q[i] <= 1'b0;
            end

            // R6: a set source always leaves the latch high, clear or not
            assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> latch_q[i]);

            // R5: a clear with no set drops the latch
            assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[i] && !set_vec[i]) |=> !latch_q[i]);

            // R4: the latch only rises when some set source was present
            assert_rise_needs_set_R4: assert property (@(posedge clk) disable iff (rst)
                $rose(latch_q[i]) |-> $past(set_vec[i]));
        end
    endgenerate

endmodule

// File: rtl/pend_tracker.sv
module pend_tracker
    import pend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sec_en,
    input  logic [NUM_PER-1:0]  line_lvl,
    input  logic [NUM_PER-1:0]  edge_cfg,
    input  logic [NUM_IRQ-1:0]  set_strobe,
    input  logic [NUM_IRQ-1:0]  clr_strobe,
    input  logic [NUM_SGI-1:0]  grp_cfg,
    input  logic [NUM_SGI-1:0]  grpmod_cfg,
    input  logic [POLICY_W-1:0] ns_policy,
    input  logic                inj_valid,
    input  logic [SGI_ID_W-1:0] inj_id,
    input  logic [1:0]          inj_grp,
    input  logic                inj_ns,
    output logic [NUM_IRQ-1:0]  pend_o,
    output logic                inj_ack,
    output logic                inj_nak
);

    inj_req_t           req;
    inj_rsp_t           rsp;
    logic [NUM_PER-1:0] lvl_q;
    logic [NUM_PER-1:0] edge_set;
    logic [NUM_SGI-1:0] sgi_set;
    logic [NUM_IRQ-1:0] set_all;
    logic [NUM_IRQ-1:0] latch_q;
    logic [NUM_IRQ-1:0] live_lvl;

    always_comb begin
        req.valid = inj_valid;
        req.id    = inj_id;
        req.grp   = grp_e'(inj_grp);
        req.ns    = inj_ns;
    end

    pend_line_sampler #(.LINES(NUM_PER)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_lvl),
        .edge_cfg (edge_cfg),
        .lvl_q    (lvl_q),
        .edge_set (edge_set)
    );

    pend_inject_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .sec_en     (sec_en),
        .req        (req),
        .grp_cfg    (grp_cfg),
        .grpmod_cfg (grpmod_cfg),
        .ns_policy  (ns_policy),
        .sgi_set    (sgi_set),
        .rsp        (rsp)
    );

    always_comb begin
        set_all  = set_strobe | {edge_set, sgi_set};
        live_lvl = {lvl_q & ~edge_cfg, {NUM_SGI{1'b0}}};
    end

    pend_latch_bank #(.BITS(NUM_IRQ)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_all),
        .clr_vec (clr_strobe),
        .latch_q (latch_q)
    );

    always_comb begin
        pend_o  = latch_q | live_lvl;
        inj_ack = rsp.ack;
        inj_nak = rsp.nak;
    end

    // R9: an acknowledged injection is visible as pending at once
    assert_ack_sets_pending_R9: assert property (@(posedge clk) disable iff (rst)
        inj_ack |-> pend_o[$past(inj_id)]);

    // R5: a level line held high stays pending across a clear
    assert_level_survives_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (lvl_q[0] && !edge_cfg[0] && line_lvl[0] && !$changed(edge_cfg[0]))
            |=> pend_o[NUM_SGI]);

    // R1: nothing is reported in the first cycle after reset
    assert_clean_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (pend_o == '0 && !inj_ack && !inj_nak));

endmodule

// File: tb/sim_pend_tracker.sv
module sim_pend_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NSGI = 16;
    localparam int NPER = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        sec_en;
    logic [15:0] line_lvl;
    logic [15:0] edge_cfg;
    logic [31:0] set_strobe;
    logic [31:0] clr_strobe;
    logic [15:0] grp_cfg;
    logic [15:0] grpmod_cfg;
    logic [31:0] ns_policy;
    logic        inj_valid;
    logic [3:0]  inj_id;
    logic [1:0]  inj_grp;
    logic        inj_ns;
    logic [31:0] pend_o;
    logic        inj_ack;
    logic        inj_nak;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pend_tracker u0 (
        .clk        (clk),
        .rst        (rst),
        .sec_en     (sec_en),
        .line_lvl   (line_lvl),
        .edge_cfg   (edge_cfg),
        .set_strobe (set_strobe),
        .clr_strobe (clr_strobe),
        .grp_cfg    (grp_cfg),
        .grpmod_cfg (grpmod_cfg),
        .ns_policy  (ns_policy),
        .inj_valid  (inj_valid),
        .inj_id     (inj_id),
        .inj_grp    (inj_grp),
        .inj_ns     (inj_ns),
        .pend_o     (pend_o),
        .inj_ack    (inj_ack),
        .inj_nak    (inj_nak)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected verdict: cfg 0 = Group 0, 1 = Secure Group 1, 2 = Non-secure Group 1
    function automatic bit expect_accept(input int req, input int cfg, input bit ns,
                                         input bit sec, input int field);
        bit ok;
        if (req == 3) return 1'b0;
        ok = (req == cfg) || (req == 1 && cfg == 0);
        if (!ok) return 1'b0;
        if (sec && ns) begin
            if (cfg == 0 && field < 1) return 1'b0;
            if (cfg == 1 && field < 2) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        rst        = 1'b1;
        sec_en     = 1'b0;
        line_lvl   = '0;
        edge_cfg   = '0;
        set_strobe = '0;
        clr_strobe = '0;
        grp_cfg    = '0;
        grpmod_cfg = '0;
        ns_policy  = '0;
        inj_valid  = 1'b0;
        inj_id     = '0;
        inj_grp    = '0;
        inj_ns     = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check32("R1 pend", pend_o, 32'h0);
        check32("R1 ack/nak", {30'd0, inj_ack, inj_nak}, 32'h0);

        // Peripheral lines: edge-triggered (e=1) and level-sensitive (e=0)
        for (int j = 0; j < NPER; j++) begin
            for (int e = 0; e < 2; e++) begin
                logic [31:0] bitv;
                bitv = 32'h1 << (NSGI + j);
                edge_cfg = (e != 0) ? (16'h1 << j) : 16'h0;
                line_lvl = 16'h1 << j;
                @(negedge clk);
                check32("R2 raise", pend_o, bitv);
                line_lvl = '0;
                @(negedge clk);
                check32("R3 lower", pend_o, (e != 0) ? bitv : 32'h0);
                line_lvl = 16'h1 << j;
                @(negedge clk);
                check32("R2 raise again", pend_o, bitv);
                clr_strobe = bitv;
                @(negedge clk);
                clr_strobe = '0;
                check32("R5 clear held line", pend_o, (e != 0) ? 32'h0 : bitv);
                @(negedge clk);
                check32("R4 held line no relatch", pend_o, (e != 0) ? 32'h0 : bitv);
                line_lvl = '0;
                @(negedge clk);
                check32("R2 final low", pend_o, 32'h0);
            end
        end
        edge_cfg = '0;

        // Set and clear on the same bit in the same cycle
        for (int k = 0; k < 32; k++) begin
            set_strobe = 32'h1 << k;
            clr_strobe = 32'h1 << k;
            @(negedge clk);
            set_strobe = '0;
            clr_strobe = '0;
            check32("R6 set wins", pend_o, 32'h1 << k);
            clr_strobe = 32'h1 << k;
            @(negedge clk);
            clr_strobe = '0;
            check32("R5 clear", pend_o, 32'h0);
        end

        // Exhaustive injection sweep
        for (int id = 0; id < NSGI; id++) begin
            for (int cfg = 0; cfg < 3; cfg++) begin
                for (int req = 0; req < 4; req++) begin
                    for (int sec = 0; sec < 2; sec++) begin
                        for (int ns = 0; ns < 2; ns++) begin
                            for (int f = 0; f < 4; f++) begin
                                bit acc;
                                logic [31:0] pol;
                                acc = expect_accept(req, cfg, ns[0], sec[0], f);
                                pol = '0;
                                for (int q = 0; q < NSGI; q++)
                                    pol[q*2 +: 2] = (q == id) ? 2'(f) : 2'(3 - f);
                                clr_strobe = '1;
                                sec_en     = sec[0];
                                grp_cfg    = (cfg == 2) ? (16'h1 << id) : ~(16'h1 << id);
                                grpmod_cfg = (cfg == 1) ? (16'h1 << id) : ~(16'h1 << id);
                                ns_policy  = pol;
                                @(negedge clk);
                                clr_strobe = '0;
                                inj_valid  = 1'b1;
                                inj_id     = 4'(id);
                                inj_grp    = 2'(req);
                                inj_ns     = ns[0];
                                @(negedge clk);
                                inj_valid  = 1'b0;
                                if (req == 3 || cfg != req)
                                    check32("R7 group verdict", {30'd0, inj_ack, inj_nak},
                                            acc ? 32'h2 : 32'h1);
                                else
                                    check32("R8 field verdict", {30'd0, inj_ack, inj_nak},
                                            acc ? 32'h2 : 32'h1);
                                check32("R9 pending after injection", pend_o,
                                        acc ? (32'h1 << id) : 32'h0);
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        report();
    end

endmodule